// File: doc/BRIEF.md
# Block Lock Protection Unit

This unit guards the erasable blocks of a 512-kword flash array against unwanted modification. It keeps one lock flag per block for the nineteen erase blocks. It turns an incoming word address into the index of the block that holds it. It then decides, in the same cycle, whether a program or erase request to that block may go ahead. It also answers lock-status queries and updates the flags when a lock-program or a permitted erase is accepted.

The nineteen blocks are one 8-kword boot block, two 4-kword parameter blocks, one 16-kword main block and fifteen 32-kword main blocks. A parameter places the small blocks either at the top or at the bottom of the word address space. Three inputs shape the decision. An active-low write-protect input enforces the lock flags. A high-voltage override input lifts every lock. A power-down input refuses everything. The sequencer that drives the array treats a request that the unit accepts as done, and takes a refusal as an error to record in its status.

Top module: `blk_lock_guard`

## Requirements
- R1: With TOP_BOOT=1, word address bits 18..15 below 4'hF give block index equal to those bits (0..14). 78000h..7BFFFh give 15, 7C000h..7CFFFh give 16, 7D000h..7DFFFh give 17 and 7E000h..7FFFFh give 18.
- R2: With TOP_BOOT=0, 00000h..01FFFh give index 0, 02000h..02FFFh give 1, 03000h..03FFFh give 2 and 04000h..07FFFh give 3. Every higher address gives bits 18..15 plus 3.
- R3: The operation code is 2'b00 program, 2'b01 erase, 2'b10 lock-program and 2'b11 lock-status read. Take a program or erase request with power-down inactive, wp_n low, hv_unlock low and the block's flag 0 (locked). That request gets permit=0. A refused program raises err_prog and a refused erase raises err_erase, in the request cycle.
- R4: When wp_n is high or hv_unlock is high, a program or erase request with power-down inactive gets permit=1 and no error, whatever the block's flag.
- R5: A permitted erase sets the addressed block's flag to 1 (unlocked) at the clock edge that ends the request cycle.
- R6: A lock-program request with power-down inactive is always permitted. It clears only the addressed block's flag to 0 at the clock edge that ends the request.
- R7: While dpd_n is low, no request is permitted, no error is raised, no flag changes and lock_rd reads 8'h00.
- R8: After rst_n is released, every block flag is 1.
- R9: A lock-status read with power-down inactive returns the addressed block's flag on lock_rd bit 6, with all other bits 0. A refused erase leaves the flag at 0.
- R10: Program requests, lock-status reads and refused requests leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the lock flags |
| dpd_n | input | 1 | Active-low power-down; low refuses all requests |
| wp_n | input | 1 | Active-low write protect; low enforces lock flags |
| hv_unlock | input | 1 | High-voltage override; high ignores lock flags |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | AW | Word address of the request |
| blk_idx | output | 5 | Block index decoded from req_addr |
| permit | output | 1 | Request accepted this cycle |
| err_prog | output | 1 | Program request refused by protection |
| err_erase | output | 1 | Erase request refused by protection |
| lock_rd | output | 8 | Lock-status read data, flag on bit 6 |

## Verification
A wrong address decode shows on blk_idx in the same cycle as the address. It also sends permits and flag updates to a neighbouring block, which then surfaces on the next status read of either block. A flag register stuck or written at the wrong index shows at the ports only when that block is read or is next addressed under write protect. Because of that, the bench reads back every block after each group of updates. A fault in the permit logic shows at once as a wrong permit/error pattern for the request in flight.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

  localparam int NUM_BLK = 19;
  localparam int IDX_W   = $clog2(NUM_BLK);
  localparam int PAGE_W  = 7;

  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_ERASE = 2'b01,
    OP_LOCK  = 2'b10,
    OP_LSTAT = 2'b11
  } op_e;

  // Small blocks at the low end of the address space.
  function automatic logic [IDX_W-1:0] low_small_index(input logic [PAGE_W-1:0] pg);
    if (pg[6:3] != 4'h0)  return IDX_W'({1'b0, pg[6:3]}) + IDX_W'(3);
    else if (pg[2])       return IDX_W'(3);
    else if (pg[1])       return pg[0] ? IDX_W'(2) : IDX_W'(1);
    else                  return IDX_W'(0);
  endfunction

  // Small blocks at the high end of the address space.
  function automatic logic [IDX_W-1:0] high_small_index(input logic [PAGE_W-1:0] pg);
    if (pg[6:3] != 4'hF)  return IDX_W'({1'b0, pg[6:3]});
    else if (!pg[2])      return IDX_W'(15);
    else if (!pg[1])      return pg[0] ? IDX_W'(17) : IDX_W'(16);
    else                  return IDX_W'(18);
  endfunction

endpackage

// File: rtl/blk_map.sv
module blk_map
  import blk_lock_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);

  generate
    if (TOP_BOOT) begin : g_top
      assign idx = high_small_index(page);
    end else begin : g_bot
      assign idx = low_small_index(page);
    end
  endgenerate

endmodule

// File: rtl/blk_lock_bits.sv
module blk_lock_bits
  import blk_lock_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_bit,
  output logic [NUM_BLK-1:0] bits_q
);

  generate
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bits_q[g] <= 1'b1;
        else if (set_en && wr_idx == IDX_W'(g))
          bits_q[g] <= 1'b1;
        else if (clr_en && wr_idx == IDX_W'(g))
          bits_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign rd_bit = (int'(rd_idx) < NUM_BLK) ? bits_q[rd_idx] : 1'b1;

endmodule

// File: rtl/blk_protect.sv
module blk_protect
  import blk_lock_pkg::*;
(
  input  logic req_valid,
  input  op_e  op,
  input  logic dpd_n,
  input  logic wp_n,
  input  logic hv_unlock,
  input  logic flag,
  output logic permit,
  output logic deny_prog,
  output logic deny_erase,
  output logic unlock_wr,
  output logic lock_wr,
  output logic powered
);

  logic modify;
  logic free;

  assign powered    = req_valid & dpd_n;
  assign modify     = (op == OP_PROG) | (op == OP_ERASE);
  assign free       = wp_n | hv_unlock | flag;
  assign permit     = powered & ((modify & free) | (op == OP_LOCK));
  assign deny_prog  = powered & (op == OP_PROG)  & ~free;
  assign deny_erase = powered & (op == OP_ERASE) & ~free;
  assign unlock_wr  = powered & (op == OP_ERASE) & free;
  assign lock_wr    = powered & (op == OP_LOCK);

endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard
  import blk_lock_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1,
  parameter int AW       = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dpd_n,
  input  logic          wp_n,
  input  logic          hv_unlock,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic [4:0]    blk_idx,
  output logic          permit,
  output logic          err_prog,
  output logic          err_erase,
  output logic [7:0]    lock_rd
);

  localparam int LOW_W = AW - PAGE_W;

  op_e                op;
  logic [IDX_W-1:0]   idx;
  logic               cur_flag;
  logic               unlock_wr;
  logic               lock_wr;
  logic               powered;
  logic [NUM_BLK-1:0] lock_q;
  logic               unused_low;

  assign op         = op_e'(req_op);
  assign unused_low = ^req_addr[LOW_W-1:0];

  blk_map #(.TOP_BOOT(TOP_BOOT)) u_map (
    .page (req_addr[AW-1 -: PAGE_W]),
    .idx  (idx)
  );

  blk_lock_bits u_bits (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (unlock_wr),
    .clr_en (lock_wr),
    .wr_idx (idx),
    .rd_idx (idx),
    .rd_bit (cur_flag),
    .bits_q (lock_q)
  );

  blk_protect u_prot (
    .req_valid  (req_valid),
    .op         (op),
    .dpd_n      (dpd_n),
    .wp_n       (wp_n),
    .hv_unlock  (hv_unlock),
    .flag       (cur_flag),
    .permit     (permit),
    .deny_prog  (err_prog),
    .deny_erase (err_erase),
    .unlock_wr  (unlock_wr),
    .lock_wr    (lock_wr),
    .powered    (powered)
  );

  assign blk_idx = 5'(idx);
  assign lock_rd = (powered && op == OP_LSTAT) ? {1'b0, cur_flag, 6'b0} : 8'h00;

endmodule

// File: rtl/blk_lock_guard_chk.sv
module blk_lock_guard_chk
  import blk_lock_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               dpd_n,
  input logic               wp_n,
  input logic               hv_unlock,
  input logic               req_valid,
  input logic [1:0]         req_op,
  input logic [4:0]         blk_idx,
  input logic               permit,
  input logic               err_prog,
  input logic               err_erase,
  input logic [7:0]         lock_rd,
  input logic [NUM_BLK-1:0] lock_q
);

  p_refuse_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dpd_n && !wp_n && !hv_unlock && !req_op[1] && !lock_q[blk_idx])
      |-> (!permit && (err_prog != err_erase)));

  p_override_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dpd_n && (wp_n || hv_unlock) && !req_op[1])
      |-> (permit && !err_prog && !err_erase));

  p_erase_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && req_op == 2'b01) |=> lock_q[$past(blk_idx)]);

  p_lockprog_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && req_op == 2'b10) |=> !lock_q[$past(blk_idx)]);

  p_powerdown_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dpd_n |-> (!permit && !err_prog && !err_erase && lock_rd == 8'h00));

  p_powerdown_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dpd_n |=> $stable(lock_q));

  p_read_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_rd & 8'hBF) == 0);

  p_no_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit && (req_op == 2'b01 || req_op == 2'b10)) |=> $stable(lock_q));

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({permit, err_prog, err_erase}));

endmodule

bind blk_lock_guard blk_lock_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dpd_n     (dpd_n),
  .wp_n      (wp_n),
  .hv_unlock (hv_unlock),
  .req_valid (req_valid),
  .req_op    (req_op),
  .blk_idx   (blk_idx),
  .permit    (permit),
  .err_prog  (err_prog),
  .err_erase (err_erase),
  .lock_rd   (lock_rd),
  .lock_q    (lock_q)
);

// File: tb/tb_blk_lock_guard.sv
module tb_blk_lock_guard;

  localparam int CLK_P = 10;
  localparam int AW    = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dpd_n = 1'b1;
  logic          wp_n = 1'b0;
  logic          hv_unlock = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b11;
  logic [AW-1:0] req_addr = '0;

  logic [4:0] idx_t, idx_b;
  logic       perm_t, perm_b, ep_t, ep_b, ee_t, ee_b;
  logic [7:0] rd_t, rd_b;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  bit  exp_lock [19];

  always #(CLK_P/2) clk = ~clk;

  blk_lock_guard #(.TOP_BOOT(1'b1), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .dpd_n(dpd_n), .wp_n(wp_n), .hv_unlock(hv_unlock),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .blk_idx(idx_t), .permit(perm_t), .err_prog(ep_t), .err_erase(ee_t), .lock_rd(rd_t)
  );

  blk_lock_guard #(.TOP_BOOT(1'b0), .AW(AW)) dut_bot (
    .clk(clk), .rst_n(rst_n), .dpd_n(dpd_n), .wp_n(wp_n), .hv_unlock(hv_unlock),
    .req_valid(1'b0), .req_op(req_op), .req_addr(req_addr),
    .blk_idx(idx_b), .permit(perm_b), .err_prog(ep_b), .err_erase(ee_b), .lock_rd(rd_b)
  );

  // Block sizes in 4-kword pages, low-end layout.
  function automatic int pages_of(input int b);
    if (b == 0) return 2;
    if (b <= 2) return 1;
    if (b == 3) return 4;
    return 8;
  endfunction

  function automatic int exp_bottom(input int p);
    int acc = 0;
    for (int b = 0; b < 19; b++) begin
      acc += pages_of(b);
      if (p < acc) return b;
    end
    return -1;
  endfunction

  function automatic int exp_top(input int p);
    return 18 - exp_bottom(127 - p);
  endfunction

  function automatic logic [AW-1:0] addr_of(input int blk);
    for (int p = 0; p < 128; p++)
      if (exp_top(p) == blk) return {p[6:0], 12'h3C5};
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] op, input int blk, input string tag);
    bit pw, fr, e_perm, e_ep, e_ee;
    logic [7:0] e_rd;
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = addr_of(blk);
    #1;
    pw     = dpd_n;
    fr     = wp_n | hv_unlock | exp_lock[blk];
    e_perm = pw & ((op == 2'b10) | (!op[1] & fr));
    e_ep   = pw & (op == 2'b00) & !fr;
    e_ee   = pw & (op == 2'b01) & !fr;
    e_rd   = (pw && op == 2'b11) ? (exp_lock[blk] ? 8'h40 : 8'h00) : 8'h00;
    chk(tag, {20'b0, perm_t, ep_t, ee_t, 1'b0, rd_t}, {20'b0, e_perm, e_ep, e_ee, 1'b0, e_rd});
    @(posedge clk);
    if (e_perm && op == 2'b01) exp_lock[blk] = 1'b1;
    if (e_perm && op == 2'b10) exp_lock[blk] = 1'b0;
    #1 req_valid = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int b = 0; b < 19; b++) req(2'b11, b, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 19; b++) exp_lock[b] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2: sweep every 4-kword page for both layouts
    for (int p = 0; p < 128; p++) begin
      @(negedge clk);
      req_addr = {p[6:0], 12'((p * 37 + 11) & 12'hFFF)};
      #1;
      chk("R1 top map", 32'(idx_t), 32'(exp_top(p)));
      chk("R2 bottom map", 32'(idx_b), 32'(exp_bottom(p)));
    end

    // R8 / R9: all flags unlocked after reset
    read_all("R8 reset flags R9");

    // R6: lock three blocks under write protect
    req(2'b10, 18, "R6 lock boot");
    req(2'b10, 3, "R6 lock mid");
    req(2'b10, 0, "R6 lock low");
    read_all("R6 readback R9");

    // R3: refused program and erase of locked blocks
    req(2'b00, 18, "R3 program locked");
    req(2'b01, 3, "R3 erase locked");
    req(2'b11, 3, "R9 refused erase keeps lock");
    req(2'b00, 0, "R3 program locked low");

    // R10: program of unlocked block leaves flags
    req(2'b00, 5, "R10 program unlocked");
    read_all("R10 readback");

    // R4 / R5: write protect released
    wp_n = 1'b1;
    req(2'b00, 18, "R4 wp high program");
    req(2'b01, 18, "R5 erase unlocks");
    wp_n = 1'b0;
    req(2'b11, 18, "R5 readback");

    // R4 / R5: high-voltage override
    hv_unlock = 1'b1;
    req(2'b00, 3, "R4 override program");
    req(2'b01, 3, "R5 override erase");
    hv_unlock = 1'b0;
    read_all("R5 after override");

    // R7: power-down refuses everything
    dpd_n = 1'b0;
    req(2'b10, 7, "R7 lock in power-down");
    req(2'b01, 0, "R7 erase in power-down");
    req(2'b11, 0, "R7 read in power-down");
    dpd_n = 1'b1;
    read_all("R7 flags unchanged");
    req(2'b01, 0, "R3 still locked after power-down");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule